// File: doc/BRIEF.md
# High Bit Error Rate Monitor

This block sits behind a block synchronizer that has already locked. On every cycle where the synchronizer presents a new block, it gives a strobe and a flag that says whether the block's two-bit sync header was invalid. The monitor counts invalid headers inside fixed time windows. When a window collects the error limit (16 by default), it raises a high-error-rate status. The link layer uses this status to decide that the received signal cannot be trusted.

A free-running window timer measures each window as a parameterised number of clock cycles. The 125 µs window becomes a cycle count for the chosen clock, and a short count can be used in simulation. Once raised, the status is released only at a window boundary where the window just ending held fewer invalid headers than the limit. The status therefore never lasts less than one full window.

A second counter records how often the monitor steps into its bad-header handling. This is each counted invalid header while the window's tally is still below the limit. The counter saturates at its largest value. A clear input zeroes it without touching the window tally, the timer or the status.

Top module: `hber_monitor`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the status and the event count. The first window then ends on the WINDOW_CYCLES-th clock edge after reset is released, and later windows follow every WINDOW_CYCLES edges.
- R2: `high_ber` goes high on the clock edge that samples the ERR_LIMIT-th counted invalid header of a window, and it is low before that edge.
- R3: The invalid-header tally restarts at every window boundary. ERR_LIMIT-1 errors at the end of one window plus one error at the start of the next never raise the status.
- R4: Once `high_ber` is high, it stays high until the end of a window. It falls on the first boundary edge whose window counted fewer than ERR_LIMIT invalid headers.
- R5: If a window that starts with the status high collects ERR_LIMIT invalid headers again, the status stays high past that window's boundary.
- R6: An invalid header is counted only when `hdr_valid` and `hdr_bad` are both 1. `hdr_bad` has no effect while `hdr_valid` is 0.
- R7: `bad_events` rises by exactly one for each counted invalid header while the window tally is below ERR_LIMIT. Further invalid headers in the same window leave it unchanged.
- R8: `bad_events` saturates at 2^EVT_W-1 and never wraps.
- R9: `cnt_clear` zeroes `bad_events` on the next edge and wins over a simultaneous increment. It does not change `high_ber` or the window tally.
- R10: An invalid header sampled on a window's last edge counts toward the window that is ending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hdr_valid | input | 1 | A new block's header is presented this cycle |
| hdr_bad | input | 1 | The presented header is invalid (qualified by hdr_valid) |
| cnt_clear | input | 1 | Zero the bad-header event counter |
| high_ber | output | 1 | High-error-rate status |
| bad_events | output | EVT_W | Saturating count of bad-header entries |

## Verification
The hardest case to reach is the one where the limit and the window boundary meet. Examples are the last error landing exactly on the boundary edge, or a tally that straddles two windows. The window position cannot be seen at the ports, so the bench counts edges from reset release and uses a 40-cycle window. This lets it place headers on chosen edges. It sweeps 0 to 20 errors per window and runs directed cases for the boundary edge, the straddle, a second bad window while flagged, and saturation.

// File: rtl/hber_pkg.sv
package hber_pkg;

    // Status machine states
    typedef enum logic [0:0] {
        HB_NORMAL = 1'b0,
        HB_HIGH   = 1'b1
    } hb_state_e;

endpackage

// File: rtl/hber_window_timer.sv
module hber_window_timer #(
    parameter int WINDOW_CYCLES = 19532
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int TW = (WINDOW_CYCLES > 2) ? $clog2(WINDOW_CYCLES) : 1;
    localparam logic [TW-1:0] LAST = TW'(WINDOW_CYCLES - 1);

    typedef struct packed {
        logic [TW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        tick  = (tmr_q.cnt == LAST);
        if (tick) begin
            tmr_d.cnt = '0;
        end else begin
            tmr_d.cnt = tmr_q.cnt + TW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end
endmodule

// File: rtl/hber_err_window.sv
module hber_err_window #(
    parameter int ERR_LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic hdr_valid,
    input  logic hdr_bad,
    input  logic tick,
    output logic limit_hit,
    output logic bad_entry
);
    localparam int EW = $clog2(ERR_LIMIT + 1);
    localparam logic [EW-1:0] LIM    = EW'(ERR_LIMIT);
    localparam logic [EW-1:0] LIM_M1 = EW'(ERR_LIMIT - 1);

    typedef struct packed {
        logic [EW-1:0] cnt;
    } ew_t;

    ew_t  win_d, win_q;
    logic accept;
    logic below;

    always_comb begin
        win_d     = win_q;
        accept    = hdr_valid & hdr_bad;
        below     = (win_q.cnt < LIM);
        bad_entry = accept & below;
        // tally reaches the limit now, or already sits there
        limit_hit = !below || (bad_entry && (win_q.cnt == LIM_M1));
        if (tick) begin
            win_d.cnt = '0;
        end else if (bad_entry) begin
            win_d.cnt = win_q.cnt + EW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q <= '0;
        end else begin
            win_q <= win_d;
        end
    end
endmodule

// File: rtl/hber_event_counter.sv
module hber_event_counter #(
    parameter int EVT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             inc,
    output logic [EVT_W-1:0] count
);
    localparam logic [EVT_W-1:0] TOP = {EVT_W{1'b1}};

    typedef struct packed {
        logic [EVT_W-1:0] cnt;
    } ev_t;

    ev_t ev_d, ev_q;

    always_comb begin
        ev_d = ev_q;
        if (clear) begin
            ev_d.cnt = '0;
        end else if (inc && (ev_q.cnt != TOP)) begin
            ev_d.cnt = ev_q.cnt + EVT_W'(1);
        end
        count = ev_q.cnt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ev_q <= '0;
        end else begin
            ev_q <= ev_d;
        end
    end
endmodule

// File: rtl/hber_monitor.sv
module hber_monitor
    import hber_pkg::*;
#(
    parameter int WINDOW_CYCLES = 19532,
    parameter int ERR_LIMIT     = 16,
    parameter int EVT_W         = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hdr_valid,
    input  logic             hdr_bad,
    input  logic             cnt_clear,
    output logic             high_ber,
    output logic [EVT_W-1:0] bad_events
);
    typedef struct packed {
        hb_state_e st;
    } fsm_t;

    fsm_t fsm_d, fsm_q;
    logic win_tick;
    logic limit_hit;
    logic bad_entry;

    hber_window_timer #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .tick (win_tick)
    );

    hber_err_window #(.ERR_LIMIT(ERR_LIMIT)) u_window (
        .clk       (clk),
        .rst       (rst),
        .hdr_valid (hdr_valid),
        .hdr_bad   (hdr_bad),
        .tick      (win_tick),
        .limit_hit (limit_hit),
        .bad_entry (bad_entry)
    );

    hber_event_counter #(.EVT_W(EVT_W)) u_events (
        .clk   (clk),
        .rst   (rst),
        .clear (cnt_clear),
        .inc   (bad_entry),
        .count (bad_events)
    );

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q.st)
            HB_NORMAL: if (limit_hit) fsm_d.st = HB_HIGH;
            HB_HIGH:   if (win_tick && !limit_hit) fsm_d.st = HB_NORMAL;
            default:   fsm_d.st = HB_NORMAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fsm_q.st <= HB_NORMAL;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign high_ber = (fsm_q.st == HB_HIGH);
endmodule

module hber_monitor_chk #(
    parameter int EVT_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             hdr_valid,
    input logic             hdr_bad,
    input logic             cnt_clear,
    input logic             win_tick,
    input logic             high_ber,
    input logic [EVT_W-1:0] bad_events
);
    localparam logic [EVT_W-1:0] TOP = {EVT_W{1'b1}};

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (!high_ber && bad_events == '0));

    // R2
    rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(high_ber) |-> $past(hdr_valid && hdr_bad));

    // R4
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (high_ber && !win_tick) |=> high_ber);

    // R6
    ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (!cnt_clear && !hdr_valid) |=> $stable(bad_events));

    // R7
    event_step_chk: assert property (@(posedge clk) disable iff (rst)
        !cnt_clear |=> ((bad_events == $past(bad_events)) ||
                        (bad_events == $past(bad_events) + EVT_W'(1))));

    // R8
    no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (bad_events == TOP && !cnt_clear) |=> (bad_events == TOP));

    // R9
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_clear |=> (bad_events == '0));

    // R9
    clear_keeps_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_clear && high_ber && !win_tick) |=> high_ber);
endmodule

bind hber_monitor hber_monitor_chk #(.EVT_W(EVT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .hdr_valid  (hdr_valid),
    .hdr_bad    (hdr_bad),
    .cnt_clear  (cnt_clear),
    .win_tick   (win_tick),
    .high_ber   (high_ber),
    .bad_events (bad_events)
);

// File: tb/tb_hber_monitor.sv
`timescale 1ns/1ps
module tb_hber_monitor;
    localparam int W     = 40;
    localparam int LIMIT = 16;
    localparam int EW    = 5;
    localparam int TOPV  = 31;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          hdr_valid = 1'b0;
    logic          hdr_bad = 1'b0;
    logic          cnt_clear = 1'b0;
    logic          high_ber;
    logic [EW-1:0] bad_events;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;

    always #2.5 clk = ~clk;

    hber_monitor #(.WINDOW_CYCLES(W), .ERR_LIMIT(LIMIT), .EVT_W(EW)) dut (
        .clk        (clk),
        .rst        (rst),
        .hdr_valid  (hdr_valid),
        .hdr_bad    (hdr_bad),
        .cnt_clear  (cnt_clear),
        .high_ber   (high_ber),
        .bad_events (bad_events)
    );

    task automatic check_val(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (edge %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic reset_dut();
        @(negedge clk);
        rst = 1'b1; hdr_valid = 1'b0; hdr_bad = 1'b0; cnt_clear = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        cyc = 0;
    endtask

    // drive at negedge, take one edge, return at next negedge
    task automatic step(input logic v, input logic b, input logic c);
        hdr_valid = v; hdr_bad = b; cnt_clear = c;
        @(posedge clk);
        cyc++;
        @(negedge clk);
        hdr_valid = 1'b0; hdr_bad = 1'b0; cnt_clear = 1'b0;
    endtask

    task automatic run_to(input int k);
        while (cyc < k) step(1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // Sweep of invalid headers per window, n = 0..20
        for (int n = 0; n <= 20; n++) begin
            reset_dut();
            check_val("R1 flag after reset", int'(high_ber), 0);
            check_val("R1 count after reset", int'(bad_events), 0);
            for (int i = 0; i < n; i++) begin
                step(1'b1, 1'b1, 1'b0);
                check_val("R2 flag timing", int'(high_ber), (i + 1 >= LIMIT) ? 1 : 0);
            end
            run_to(W - 1);
            check_val("R4 flag before boundary", int'(high_ber), (n >= LIMIT) ? 1 : 0);
            run_to(W);
            check_val("R3 flag at first boundary", int'(high_ber), (n >= LIMIT) ? 1 : 0);
            check_val("R7 events per window", int'(bad_events), (n < LIMIT) ? n : LIMIT);
            run_to(2 * W - 1);
            check_val("R4 held one window", int'(high_ber), (n >= LIMIT) ? 1 : 0);
            run_to(2 * W);
            check_val("R4 cleared after clean window", int'(high_ber), 0);
        end

        // R3: tally straddles a boundary
        reset_dut();
        run_to(W - 15);
        for (int i = 0; i < 15; i++) step(1'b1, 1'b1, 1'b0);
        step(1'b1, 1'b1, 1'b0);
        check_val("R3 straddle no flag", int'(high_ber), 0);
        check_val("R7 straddle count", int'(bad_events), 16);
        run_to(2 * W);
        check_val("R3 straddle still no flag", int'(high_ber), 0);

        // R10: limit reached on the boundary edge
        reset_dut();
        for (int i = 0; i < 15; i++) step(1'b1, 1'b1, 1'b0);
        run_to(W - 1);
        check_val("R10 flag low before last edge", int'(high_ber), 0);
        step(1'b1, 1'b1, 1'b0);
        check_val("R10 boundary header counted", int'(high_ber), 1);
        run_to(2 * W - 1);
        check_val("R10 flag held next window", int'(high_ber), 1);
        run_to(2 * W);
        check_val("R10 flag released", int'(high_ber), 0);

        // R5 and R8: second bad window, saturation
        reset_dut();
        for (int i = 0; i < 16; i++) step(1'b1, 1'b1, 1'b0);
        run_to(W);
        for (int i = 0; i < 16; i++) step(1'b1, 1'b1, 1'b0);
        run_to(2 * W);
        check_val("R5 flag kept by bad window", int'(high_ber), 1);
        check_val("R8 count saturated", int'(bad_events), TOPV);
        run_to(3 * W);
        check_val("R5 flag released later", int'(high_ber), 0);
        for (int i = 0; i < 16; i++) step(1'b1, 1'b1, 1'b0);
        check_val("R8 count stays at top", int'(bad_events), TOPV);
        check_val("R2 flag set in third bad window", int'(high_ber), 1);
        reset_dut();
        check_val("R1 reset clears flag", int'(high_ber), 0);
        check_val("R1 reset clears count", int'(bad_events), 0);

        // R6: unqualified headers ignored
        reset_dut();
        for (int i = 0; i < W; i++) step(1'b0, 1'b1, 1'b0);
        check_val("R6 no count without strobe", int'(bad_events), 0);
        check_val("R6 no flag without strobe", int'(high_ber), 0);
        for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 1'b0);
        check_val("R6 good headers not counted", int'(bad_events), 0);
        reset_dut();
        for (int i = 0; i < 15; i++) step(1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 10; i++) step(1'b0, 1'b1, 1'b0);
        check_val("R6 ignored headers left count", int'(bad_events), 15);
        run_to(W);
        check_val("R6 ignored headers no flag", int'(high_ber), 0);

        // R9: clear priority, no effect on tally or flag
        reset_dut();
        for (int i = 0; i < 10; i++) step(1'b1, 1'b1, 1'b0);
        check_val("R7 ten events", int'(bad_events), 10);
        step(1'b1, 1'b1, 1'b1);
        check_val("R9 clear wins over increment", int'(bad_events), 0);
        check_val("R9 flag low after clear", int'(high_ber), 0);
        for (int i = 0; i < 5; i++) step(1'b1, 1'b1, 1'b0);
        check_val("R9 tally undisturbed by clear", int'(high_ber), 1);
        check_val("R9 count after clear", int'(bad_events), 5);
        step(1'b0, 1'b0, 1'b1);
        check_val("R9 clear while flagged", int'(bad_events), 0);
        check_val("R9 flag unchanged by clear", int'(high_ber), 1);
        run_to(W);
        check_val("R9 flag kept at boundary", int'(high_ber), 1);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule